// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block turns a stream of frame bytes into the serial bit stream of a bit-oriented synchronous link. A producer hands over address, control and information bytes one at a time on a byte-wide valid/ready interface and marks the final byte of each frame with an end marker. The block emits one line bit on every cycle in which the clock-enable input is high. It wraps each frame in 0x7E delimiters, appends a 16-bit cyclic check computed over the frame content, and inserts a zero after every run of five content ones so that no flag pattern can appear inside a frame.

When nothing is queued, the line carries back-to-back flags. A configuration input chooses whether the closing flag of one frame may also open the next one, or whether a separate opening flag must follow. A second configuration input gives the address length (one to four bytes). An end marker that arrives before the address bytes and one control byte have all been accepted is disregarded. The block keeps no byte buffer: it pulls each byte exactly when the previous unit's last bit leaves. If the producer has nothing at that moment inside a frame, the frame is closed at once with the check sequence over the bytes sent so far.

Top module: `hdlc_tx_engine`

## Requirements
- R1: While reset is held, `tx_bit` is 1 and `s_ready` is 0. The first enabled bits after reset form a flag.
- R2: With no byte accepted, the line repeats the flag 0x7E, sent bit 0 first (bit order 0,1,1,1,1,1,1,0).
- R3: Each accepted byte is sent bit 0 first, in acceptance order. The first byte of a frame directly follows the flag at whose last bit it was accepted.
- R4: Right after the last byte, the 16-bit check is sent. The check register starts at 0xFFFF. It is advanced by every data bit in line order with the polynomial 0x1021: shift left, XOR with 0x1021 when the old bit 15 differed from the data bit. The register is complemented and sent bit 15 first.
- R5: The check is followed immediately by a closing flag (after any stuffed zero).
- R6: After five consecutive content ones (data or check bits), one 0 bit is inserted, also when the next unit is the closing flag. Flag bits are never stuffed and restart the run count.
- R7: With `cfg_shared_flag`=1, a byte can be accepted at the last bit of a closing flag. With 0, no byte is accepted there, so at least one more flag separates frames.
- R8: `s_ready` is high only in an enabled cycle that sends the last bit of an eligible flag, or of a data byte not closing its frame. It is never high during check bits, stuffed zeros or disabled cycles.
- R9: `cfg_addr_len` holds the address byte count minus one. `s_last` ends the frame only on a byte whose position in the frame is at least `cfg_addr_len`+2. An earlier end marker is ignored.
- R10: If `s_valid` is low when `s_ready` is offered at the end of a data byte, the frame closes with the check over the bytes already sent.
- R11: `tx_bit` changes only at clock edges where `bit_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Line bit enable; one line bit per enabled cycle |
| cfg_shared_flag | input | 1 | 1: closing flag may open the next frame |
| cfg_addr_len | input | 2 | Address bytes minus one |
| s_valid | input | 1 | Byte offered |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Byte is the last of its frame |
| s_ready | output | 1 | Byte taken this cycle when `s_valid` is high |
| tx_bit | output | 1 | Serial line bit |

## Verification
A behavioural line model built from bit queues predicts `s_ready` and `tx_bit` on every clock. It is driven with several patterns:
- Idle periods separate the interframe flag fill from frame content.
- Runs of 0xFF bytes force stuffing inside data and, by chance, inside the check.
- Back-to-back frames under both flag modes separate the shared-flag and double-flag gaps.
- Early end markers with a four-byte address exercise the minimum-length rule.
- A starved producer shows whether an underrun closes the frame.

The same frames are also sent with the bit enable high on only every third cycle. This separates enable-driven timing from clock-driven timing.

// File: rtl/hdlctx_pkg.sv
package hdlctx_pkg;

    // Unit currently being shifted onto the line
    typedef enum logic [1:0] {
        PH_FLAG = 2'd0,
        PH_DATA = 2'd1,
        PH_FCS  = 2'd2
    } phase_t;

    localparam int unsigned   DEF_BYTE_W   = 8;
    localparam int unsigned   DEF_FCS_W    = 16;
    localparam int unsigned   DEF_RUN_LEN  = 5;
    localparam int unsigned   DEF_ADDR_MAX = 4;
    localparam logic [15:0]   DEF_POLY     = 16'h1021;
    localparam logic [7:0]    DEF_FLAG     = 8'h7E;

endpackage

// File: rtl/hdlctx_stuffer.sv
// Zero-insertion tracker.
// Counts consecutive content ones that have been put on the line and raises
// stuff_now once RUN_LEN of them have gone out. The caller must then emit a 0
// instead of its own next bit.
// Assumes: adv marks each line bit; content is low for flag bits.
module hdlctx_stuffer #(
    parameter int unsigned RUN_LEN = 5,
    localparam int unsigned OW     = $clog2(RUN_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic content,
    input  logic bit_val,
    output logic stuff_now
);

    logic [OW-1:0] ones;

    // Run limit reached: the next line bit must be an inserted zero
    always_comb stuff_now = (ones == OW'(RUN_LEN));

    // Track the run of content ones; flags and stuffed zeros clear it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones <= '0;
        end else if (adv) begin
            if (stuff_now) begin
                ones <= '0;
            end else if (content && bit_val) begin
                ones <= ones + OW'(1);
            end else begin
                ones <= '0;
            end
        end
    end

    // R6: the run counter never passes the limit
    a_r6_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= OW'(RUN_LEN));

endmodule

// File: rtl/hdlctx_crc.sv
// Frame check register.
// Presets to all ones, advances one data bit at a time with POLY in
// non-reflected form, and then shifts the complemented result out from the
// top bit.
// Assumes: init, upd and shift are never raised together.
module hdlctx_crc #(
    parameter int unsigned     W    = 16,
    parameter logic [W-1:0]    POLY = 16'h1021
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic upd,
    input  logic shift,
    input  logic bit_in,
    output logic fcs_bit
);

    logic [W-1:0] crc;
    logic         fb;

    // Feedback term and outgoing complemented top bit
    always_comb begin
        fb      = crc[W-1] ^ bit_in;
        fcs_bit = ~crc[W-1];
    end

    // Preset, divide by the polynomial, or shift the result out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc <= '1;
        end else if (init) begin
            crc <= '1;
        end else if (upd) begin
            crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end else if (shift) begin
            crc <= {crc[W-2:0], 1'b0};
        end
    end

    // R4: a frame start always leaves the register preset
    a_r4_preset: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (crc == '1));

endmodule

// File: rtl/hdlctx_seq.sv
// Frame sequencer.
// Chooses the next line bit from the flag pattern, the current data byte or
// the check register. It offers s_ready exactly when the last bit of a unit
// leaves, pulls bytes, applies the minimum-length rule to the end marker,
// and closes frames on an end marker or an underrun.
// Assumes: configuration inputs stay stable while a frame is in flight.
module hdlctx_seq
    import hdlctx_pkg::*;
#(
    parameter int unsigned        BYTE_W   = 8,
    parameter int unsigned        FCS_W    = 16,
    parameter int unsigned        ADDR_MAX = 4,
    parameter logic [BYTE_W-1:0]  FLAG_PAT = 8'h7E,
    localparam int unsigned       AL_W     = $clog2(ADDR_MAX),
    localparam int unsigned       NB_W     = $clog2(ADDR_MAX + 2) + 1,
    localparam int unsigned       CNT_W    = $clog2(FCS_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              cfg_shared_flag,
    input  logic [AL_W-1:0]   cfg_addr_len,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    input  logic              stuff_now,
    input  logic              fcs_bit,
    output logic              s_ready,
    output logic              line_bit,
    output logic              content,
    output logic              crc_init,
    output logic              crc_upd,
    output logic              crc_shift
);

    localparam logic [NB_W-1:0] NB_MAX = NB_W'(ADDR_MAX + 1);

    phase_t              phase;
    logic [CNT_W-1:0]    cnt;
    logic [BYTE_W-1:0]   shreg;
    logic                closing;
    logic                close_after;
    logic [NB_W-1:0]     nbytes;

    logic [CNT_W-1:0]    last_idx;
    logic                unit_end;
    logic                open_ok;
    logic                take;
    logic [BYTE_W-1:0]   flag_shift;
    logic [NB_W-1:0]     next_count;
    logic [NB_W-1:0]     min_bytes;
    logic                byte_closes;
    logic                step;

    // Unit boundary, readiness and line-bit selection
    always_comb begin
        last_idx    = (phase == PH_FCS) ? CNT_W'(FCS_W - 1) : CNT_W'(BYTE_W - 1);
        unit_end    = (cnt == last_idx) && !stuff_now;
        open_ok     = !closing || cfg_shared_flag;
        step        = adv && !stuff_now;
        s_ready     = adv && unit_end &&
                      (((phase == PH_FLAG) && open_ok) ||
                       ((phase == PH_DATA) && !close_after));
        take        = s_ready && s_valid;
        flag_shift  = FLAG_PAT >> cnt;
        min_bytes   = NB_W'(cfg_addr_len) + NB_W'(2);
        if (phase == PH_FLAG) begin
            next_count = NB_W'(1);
        end else if (nbytes == NB_MAX) begin
            next_count = nbytes;
        end else begin
            next_count = nbytes + NB_W'(1);
        end
        byte_closes = s_last && (next_count >= min_bytes);
        unique case (phase)
            PH_DATA: line_bit = shreg[0];
            PH_FCS:  line_bit = fcs_bit;
            default: line_bit = flag_shift[0];
        endcase
        if (stuff_now) begin
            line_bit = 1'b0;
        end
        content   = (phase != PH_FLAG);
        crc_init  = take && (phase == PH_FLAG);
        crc_upd   = step && (phase == PH_DATA);
        crc_shift = step && (phase == PH_FCS);
    end

    // Advance bit counters, load bytes and move between units
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_FLAG;
            cnt         <= '0;
            shreg       <= '0;
            closing     <= 1'b0;
            close_after <= 1'b0;
            nbytes      <= '0;
        end else if (step) begin
            cnt <= unit_end ? '0 : cnt + CNT_W'(1);
            if (phase == PH_DATA) begin
                shreg <= shreg >> 1;
            end
            if (unit_end) begin
                unique case (phase)
                    PH_FLAG: begin
                        closing <= 1'b0;
                        if (take) begin
                            phase       <= PH_DATA;
                            shreg       <= s_data;
                            nbytes      <= next_count;
                            close_after <= byte_closes;
                        end
                    end
                    PH_DATA: begin
                        if (take) begin
                            shreg       <= s_data;
                            nbytes      <= next_count;
                            close_after <= byte_closes;
                        end else begin
                            phase <= PH_FCS;
                        end
                    end
                    default: begin
                        phase   <= PH_FLAG;
                        closing <= 1'b1;
                    end
                endcase
            end
        end
    end

    // R9: a frame is only marked for closing once it is long enough
    a_r9_close_needs_min: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && close_after) |-> (nbytes >= min_bytes));

    // R5: the last check bit is followed by the start of a closing flag
    a_r5_flag_after_fcs: assert property (@(posedge clk) disable iff (!rst_n)
        (step && phase == PH_FCS && cnt == CNT_W'(FCS_W - 1))
        |=> (phase == PH_FLAG && closing && cnt == '0));

    // R7: in double-flag mode the closing flag never opens a frame
    a_r7_no_open_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FLAG && closing && !cfg_shared_flag) |-> !s_ready);

    // R8: no byte is pulled during check bits or stuffed zeros
    a_r8_no_ready_in_fcs: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FCS || stuff_now) |-> !s_ready);

endmodule

// File: rtl/hdlc_tx_engine.sv
// HDLC frame transmitter top.
// Wires the sequencer, the check register and the zero-insertion tracker,
// and registers the selected bit onto tx_bit on every enabled cycle.
// Assumes: cfg inputs change only while the line idles with flags; the
// producer drives s_valid/s_data/s_last independently of s_ready.
module hdlc_tx_engine
    import hdlctx_pkg::*;
#(
    parameter int unsigned        BYTE_W   = DEF_BYTE_W,
    parameter int unsigned        FCS_W    = DEF_FCS_W,
    parameter logic [FCS_W-1:0]   FCS_POLY = DEF_POLY,
    parameter int unsigned        RUN_LEN  = DEF_RUN_LEN,
    parameter int unsigned        ADDR_MAX = DEF_ADDR_MAX,
    parameter logic [BYTE_W-1:0]  FLAG_PAT = DEF_FLAG,
    localparam int unsigned       AL_W     = $clog2(ADDR_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              cfg_shared_flag,
    input  logic [AL_W-1:0]   cfg_addr_len,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              tx_bit
);

    logic line_bit;
    logic content;
    logic stuff_now;
    logic fcs_bit;
    logic crc_init;
    logic crc_upd;
    logic crc_shift;

    hdlctx_seq #(
        .BYTE_W   (BYTE_W),
        .FCS_W    (FCS_W),
        .ADDR_MAX (ADDR_MAX),
        .FLAG_PAT (FLAG_PAT)
    ) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .adv             (bit_en),
        .cfg_shared_flag (cfg_shared_flag),
        .cfg_addr_len    (cfg_addr_len),
        .s_valid         (s_valid),
        .s_data          (s_data),
        .s_last          (s_last),
        .stuff_now       (stuff_now),
        .fcs_bit         (fcs_bit),
        .s_ready         (s_ready),
        .line_bit        (line_bit),
        .content         (content),
        .crc_init        (crc_init),
        .crc_upd         (crc_upd),
        .crc_shift       (crc_shift)
    );

    hdlctx_crc #(
        .W    (FCS_W),
        .POLY (FCS_POLY)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (crc_init),
        .upd     (crc_upd),
        .shift   (crc_shift),
        .bit_in  (line_bit),
        .fcs_bit (fcs_bit)
    );

    hdlctx_stuffer #(
        .RUN_LEN (RUN_LEN)
    ) u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (bit_en),
        .content   (content),
        .bit_val   (line_bit),
        .stuff_now (stuff_now)
    );

    // Line register: idles high in reset, updates once per enabled cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit <= 1'b1;
        end else if (bit_en) begin
            tx_bit <= line_bit;
        end
    end

    // R11: the line holds between enabled cycles
    a_r11_hold_between_enables: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));

    // R6: an inserted bit reaches the line as a zero
    a_r6_stuff_emits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && stuff_now) |=> !tx_bit);

endmodule

// File: tb/hdlc_tx_engine_bench.sv
module hdlc_tx_engine_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_en;
    logic       cfg_shared_flag;
    logic [1:0] cfg_addr_len;
    logic       s_valid;
    logic [7:0] s_data;
    logic       s_last;
    logic       s_ready;
    logic       tx_bit;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    hdlc_tx_engine u_hdlc_tx_engine (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_en          (bit_en),
        .cfg_shared_flag (cfg_shared_flag),
        .cfg_addr_len    (cfg_addr_len),
        .s_valid         (s_valid),
        .s_data          (s_data),
        .s_last          (s_last),
        .s_ready         (s_ready),
        .tx_bit          (tx_bit)
    );

    // stimulus: {last, data}
    int stim[$];
    // line model: bit | kind<<1, kind 0 flag, 1 data, 2 check
    int mq[$];
    int m_cur, m_ones, m_nbytes;
    bit m_closing, m_close_after;
    logic [15:0] m_crc;
    logic exp_tx;
    int   en_div = 1;
    int   cyc = 0;
    string scen = "";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s (%s): actual %0d expected %0d", req, scen, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
        logic [15:0] r;
        r = c << 1;
        if (c[15] != b) r = r ^ 16'h1021;
        return r;
    endfunction

    task automatic push_flag();
        for (int i = 0; i < 8; i++) mq.push_back(int'((8'h7E >> i) & 1));
    endtask

    task automatic push_byte(input int d);
        for (int i = 0; i < 8; i++) mq.push_back(((d >> i) & 1) | 2);
    endtask

    task automatic push_fcs();
        logic [15:0] f;
        f = ~m_crc;
        for (int i = 15; i >= 0; i--) mq.push_back(int'(f[i]) | 4);
        m_cur = 2;
    endtask

    task automatic model_reset();
        mq.delete();
        push_flag();
        m_cur = 0; m_ones = 0; m_nbytes = 0;
        m_closing = 0; m_close_after = 0; m_crc = 16'hFFFF;
        exp_tx = 1'b1;
    endtask

    // one model step for an enabled cycle; returns expected ready and bit
    task automatic model_step(output bit er, output logic eb, output int ek, output bit took);
        int it;
        er = 0; took = 0;
        if (m_ones == 5) begin
            eb = 1'b0; ek = 3; m_ones = 0;
            return;
        end
        it = mq.pop_front();
        eb = it[0];
        ek = it >> 1;
        if (ek != 0) m_ones = eb ? m_ones + 1 : 0;
        else m_ones = 0;
        if (ek == 1) m_crc = crc_bit(m_crc, eb);
        if (mq.size() != 0) return;
        if (m_cur == 0) begin
            if (!m_closing || cfg_shared_flag) begin
                er = 1;
                if (s_valid) begin
                    m_crc = 16'hFFFF;
                    m_nbytes = 1;
                    m_close_after = s_last && (m_nbytes >= cfg_addr_len + 2);
                    push_byte(s_data);
                    m_cur = 1; took = 1;
                end else begin
                    push_flag();
                end
            end else begin
                push_flag();
            end
            m_closing = 0;
        end else if (m_cur == 1) begin
            if (!m_close_after) begin
                er = 1;
                if (s_valid) begin
                    if (m_nbytes < 5) m_nbytes++;
                    m_close_after = s_last && (m_nbytes >= cfg_addr_len + 2);
                    push_byte(s_data);
                    took = 1;
                end else begin
                    push_fcs();
                end
            end else begin
                push_fcs();
            end
        end else begin
            push_flag();
            m_closing = 1;
            m_cur = 0;
        end
    endtask

    task automatic tick();
        bit   er, took;
        logic eb;
        int   ek;
        bit   en;
        @(negedge clk);
        en = ((cyc % en_div) == 0);
        cyc++;
        bit_en  = en;
        s_valid = (stim.size() > 0);
        s_data  = s_valid ? stim[0][7:0] : 8'h00;
        s_last  = s_valid ? stim[0][8]   : 1'b0;
        #1;
        er = 0; took = 0; eb = exp_tx; ek = -1;
        if (en) model_step(er, eb, ek, took);
        check(s_ready === er, "R8", "s_ready offer", int'(s_ready), int'(er));
        @(posedge clk);
        #1;
        if (took) void'(stim.pop_front());
        if (en) begin
            exp_tx = eb;
            case (ek)
                0: check(tx_bit === eb, "R2/R5", "flag bit", int'(tx_bit), int'(eb));
                1: check(tx_bit === eb, "R3", "data bit", int'(tx_bit), int'(eb));
                2: check(tx_bit === eb, "R4", "check bit", int'(tx_bit), int'(eb));
                default: check(tx_bit === eb, "R6", "stuffed zero", int'(tx_bit), int'(eb));
            endcase
        end else begin
            check(tx_bit === exp_tx, "R11", "held bit", int'(tx_bit), int'(exp_tx));
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic drain();
        while (stim.size() > 0) tick();
        run(60 * en_div);
    endtask

    task automatic push_frame(input int len, input bit biased);
        int d;
        for (int i = 0; i < len; i++) begin
            d = (biased && ($urandom % 2 == 0)) ? 8'hFF : int'($urandom % 256);
            stim.push_back(d | ((i == len - 1) ? 256 : 0));
        end
    endtask

    initial begin
        rst_n = 0; bit_en = 0; s_valid = 0; s_data = 0; s_last = 0;
        cfg_shared_flag = 0; cfg_addr_len = 0;
        repeat (3) @(posedge clk);
        #1;
        check(tx_bit === 1'b1, "R1", "reset line level", int'(tx_bit), 1);
        check(s_ready === 1'b0, "R1", "reset ready", int'(s_ready), 0);
        @(negedge clk);
        rst_n = 1;
        model_reset();

        // R1/R2: idle flag fill after reset
        scen = "R1 idle";
        run(24);

        // R3/R4/R5/R6: frames with long ones runs, double-flag gap (R7)
        scen = "R7 double";
        stim.push_back(8'h03); stim.push_back(8'h3F);
        stim.push_back(8'h12); stim.push_back(8'h34 | 256);
        stim.push_back(8'hFF); stim.push_back(8'hFF); stim.push_back(8'hFF | 256);
        drain();

        // R7: shared flag mode, back-to-back frames, sparse enable (R11)
        scen = "R7 shared";
        cfg_shared_flag = 1;
        en_div = 3;
        push_frame(6, 1'b1);
        push_frame(5, 1'b0);
        drain();

        // R9: four address bytes, early end markers ignored
        scen = "R9 early last";
        en_div = 1;
        cfg_shared_flag = 0;
        cfg_addr_len = 2'd3;
        stim.push_back(8'hA1 | 256); stim.push_back(8'hA2 | 256);
        stim.push_back(8'hA3); stim.push_back(8'hA4 | 256);
        stim.push_back(8'hC0 | 256);
        stim.push_back(8'h55); stim.push_back(8'h66 | 256);
        drain();

        // R10: producer starves mid frame
        scen = "R10 underrun";
        cfg_addr_len = 2'd0;
        stim.push_back(8'h11); stim.push_back(8'h22); stim.push_back(8'h33);
        drain();
        push_frame(3, 1'b0);
        drain();

        // R4/R6: random frames, mixed modes and enables
        scen = "R4 random";
        for (int f = 0; f < 12; f++) begin
            cfg_shared_flag = f[0];
            cfg_addr_len    = 2'(f % 4);
            en_div          = (f % 3 == 0) ? 2 : 1;
            push_frame(6 + (f % 5), 1'b1);
            push_frame(5 + (f % 3), 1'b1);
            drain();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule